// File: doc/BRIEF.md
# Bidirectional Reset Sequencer with Source Flags

This block combines an active-low external reset pin with internal software and watchdog reset requests. It produces one core reset and keeps a one-hot record of what caused the last reset. When software has armed pin driving, an internal request also pulls the shared pin low, so that the devices on the board reset together with the chip. The pin is released when the fixed-length internal sequence ends. A separate active-low disable input vetoes pin driving, both at the start of a sequence and while the pin is being driven.

The pin input passes through a delay-line filter, so the filtered level trails the real pin. A fixed number of cycles after each sequence ends, the filtered level is sampled. If it is still low, a hardware reset sequence begins and its flag replaces the software or watchdog flag. This happens when the chip's own pulldown has not yet cleared the filter. An extend option, latched when a software or watchdog sequence starts, keeps the core in reset for extra cycles after the pin is released, so that the filter has cleared before the sample.

A hardware reset is classed as long or short by how many cycles the filtered pin stays low. Every sequence disarms pin driving. The flags survive resets and only a software clear empties them.

Top module: `rst_seq_ctrl`

## Requirements
- R1: After rst_ni is released, pin_pd_o and core_rst_o are 0, flags_o is 4'b0000 and pin driving is disarmed.
- R2: A low on pin_i reaches the sequencer FILT_DLY (default 12) cycles later through the filter. A filtered low while no sequence runs starts a hardware sequence: core_rst_o is asserted and pin_pd_o stays 0.
- R3: A hardware reset whose pin low lasts fewer than LONG_MIN (default 1032) sampled cycles sets flags_o to 4'b0001 (short). One lasting LONG_MIN or more cycles sets 4'b0010 (long).
- R4: A request with no sequence running starts a sequence. sw_req_i sets flags_o to 4'b0100 and wdt_req_i sets 4'b1000. If both arrive in the same cycle, watchdog wins. Without drive or extension, core_rst_o stays high for SEQ_LEN+SMP_DLY = 1032 cycles.
- R5: When pin driving is armed and drv_dis_ni is high, pin_pd_o rises together with core_rst_o and stays high for exactly SEQ_LEN (1024) cycles.
- R6: Arming is done by a bden_set_i pulse while core_rst_o is low. A pulse while core_rst_o is high is ignored. Every sequence start disarms, so a later request drives the pin only after a fresh arm.
- R7: If drv_dis_ni is low when a request starts, the pin is not driven, and the core reset length is unchanged.
- R8: If drv_dis_ni falls while the pin is driven, pin_pd_o drops in that same cycle and stays low for the rest of the sequence. The core reset still runs its full length.
- R9: SMP_DLY (8) cycles after a sequence ends, the filtered pin is sampled. If it is low, a hardware sequence follows and flags_o becomes 4'b0001. With the defaults, an unextended driven sequence always ends this way.
- R10: If ext_i is high when a request starts, the core reset lasts EXT_LEN (16) cycles longer (1048 cycles in total) while the pin is still released after 1024 cycles. No hardware reset follows, and the request's flag remains.
- R11: flags_o is one-hot or zero. It changes only when a sequence records a source or when flag_clr_i is pulsed, which clears it. Requests arriving while core_rst_o is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| pin_i | input | 1 | Level seen on the shared reset pin (low = reset) |
| drv_dis_ni | input | 1 | Active-low veto on driving the pin |
| sw_req_i | input | 1 | Software reset request |
| wdt_req_i | input | 1 | Watchdog reset request |
| bden_set_i | input | 1 | Software write that arms pin driving |
| flag_clr_i | input | 1 | Software write that clears the source flags |
| ext_i | input | 1 | Extend the internal reset past the filter delay |
| pin_pd_o | output | 1 | Pulldown on the shared reset pin |
| core_rst_o | output | 1 | Reset to the core |
| flags_o | output | 4 | Source flags: bit0 short hw, bit1 long hw, bit2 software, bit3 watchdog |

## Verification
The delicate overlap is between the release of the chip's own pulldown and the post-sequence sample of the filtered pin. The filter still shows the low the block itself drove, so the sample and that low meet in the same cycle. The bench provokes this with armed requests with and without ext_i, and judges the outcome by the final flags_o and the core reset length. A second overlap, software and watchdog requests in one cycle, is checked by the flag that wins. Random iterations mix arming, veto and extension against a bench model of the expected flags and durations.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_RUN, ST_WAIT} seq_st_e;
  localparam int unsigned FLAG_W   = 4;
  localparam int unsigned FL_SHORT = 0;
  localparam int unsigned FL_LONG  = 1;
  localparam int unsigned FL_SW    = 2;
  localparam int unsigned FL_WDT   = 3;
endpackage

// File: rtl/rst_pin_filt.sv
module rst_pin_filt #(
  parameter int unsigned DLY = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic pin_f_o
);
  logic [DLY-1:0] sh_q;

  generate
    if (DLY == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh_q <= '1;
        else         sh_q <= pin_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh_q <= '1;
        else         sh_q <= {sh_q[DLY-2:0], pin_i};
    end
  endgenerate

  assign pin_f_o = sh_q[DLY-1];
endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
  import rst_seq_pkg::*;
#(
  parameter int unsigned SEQ_LEN  = 1024,
  parameter int unsigned EXT_LEN  = 16,
  parameter int unsigned SMP_DLY  = 8,
  parameter int unsigned LONG_MIN = 1032
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_f_i,
  input  logic              sw_req_i,
  input  logic              wdt_req_i,
  input  logic              ext_i,
  input  logic              bden_i,
  input  logic              drv_dis_ni,
  output logic              pin_pd_o,
  output logic              core_rst_o,
  output logic              seq_start_o,
  output logic              flag_set_o,
  output logic [FLAG_W-1:0] flag_val_o
);
  localparam int unsigned RUN_MAX = SEQ_LEN + EXT_LEN;
  localparam int unsigned CNT_MAX = (RUN_MAX > LONG_MIN) ? RUN_MAX : LONG_MIN;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] SEQ_END  = CNT_W'(SEQ_LEN - 1);
  localparam logic [CNT_W-1:0] EXT_END  = CNT_W'(RUN_MAX - 1);
  localparam logic [CNT_W-1:0] SMP_END  = CNT_W'(SMP_DLY - 1);
  localparam logic [CNT_W-1:0] LONG_LIM = CNT_W'(LONG_MIN);

  seq_st_e          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ext_q, ext_d, drv_q, drv_d;
  logic [CNT_W-1:0] run_end;

  assign run_end = ext_q ? EXT_END : SEQ_END;

  always_comb begin
    st_d        = st_q;
    cnt_d       = cnt_q;
    ext_d       = ext_q;
    drv_d       = drv_q;
    seq_start_o = 1'b0;
    flag_set_o  = 1'b0;
    flag_val_o  = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (!pin_f_i) begin
          st_d        = ST_LOW;
          cnt_d       = CNT_W'(1);
          seq_start_o = 1'b1;
        end else if (sw_req_i || wdt_req_i) begin
          st_d        = ST_RUN;
          cnt_d       = '0;
          ext_d       = ext_i;
          drv_d       = bden_i && drv_dis_ni;
          seq_start_o = 1'b1;
          flag_set_o  = 1'b1;
          if (wdt_req_i) flag_val_o[FL_WDT] = 1'b1;
          else           flag_val_o[FL_SW]  = 1'b1;
        end
      end
      ST_LOW: begin
        if (!pin_f_i) begin
          if (cnt_q < LONG_LIM) cnt_d = cnt_q + 1'b1;
        end else begin
          st_d       = ST_RUN;
          cnt_d      = '0;
          ext_d      = 1'b0;
          flag_set_o = 1'b1;
          if (cnt_q >= LONG_LIM) flag_val_o[FL_LONG]  = 1'b1;
          else                   flag_val_o[FL_SHORT] = 1'b1;
        end
      end
      ST_RUN: begin
        if (!drv_dis_ni || cnt_q == SEQ_END) drv_d = 1'b0;
        if (cnt_q == run_end) begin
          st_d  = ST_WAIT;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        if (cnt_q == SMP_END) begin
          if (!pin_f_i) begin
            // lingering filtered low turns into a hardware reset
            st_d        = ST_LOW;
            cnt_d       = CNT_W'(1);
            seq_start_o = 1'b1;
          end else begin
            st_d = ST_IDLE;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      ext_q <= 1'b0;
      drv_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      ext_q <= ext_d;
      drv_q <= drv_d;
    end
  end

  assign pin_pd_o   = drv_q && drv_dis_ni;
  assign core_rst_o = (st_q != ST_IDLE);

  assert_pd_in_seq_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_pd_o |-> core_rst_o);
  assert_pd_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pin_pd_o) |-> $rose(core_rst_o));
  assert_dis_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drv_dis_ni |=> !pin_pd_o);
  assert_busy_no_flag_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_rst_o && flag_set_o) |-> pin_f_i);
endmodule

// File: rtl/rst_src_flags.sv
module rst_src_flags
  import rst_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flag_set_i,
  input  logic [FLAG_W-1:0] flag_val_i,
  input  logic              flag_clr_i,
  input  logic              bden_set_i,
  input  logic              seq_start_i,
  input  logic              core_rst_i,
  output logic [FLAG_W-1:0] flags_o,
  output logic              bden_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_o <= '0;
      bden_o  <= 1'b0;
    end else begin
      if (flag_set_i)      flags_o <= flag_val_i;
      else if (flag_clr_i) flags_o <= '0;
      if (seq_start_i)                   bden_o <= 1'b0;
      else if (bden_set_i && !core_rst_i) bden_o <= 1'b1;
    end
  end

  assert_flags_onehot_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(flags_o));
  assert_flags_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_set_i && !flag_clr_i) |=> $stable(flags_o));
  assert_bden_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_start_i |=> !bden_o);
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
#(
  parameter int unsigned SEQ_LEN  = 1024,
  parameter int unsigned FILT_DLY = 12,
  parameter int unsigned SMP_DLY  = 8,
  parameter int unsigned LONG_MIN = 1032,
  parameter int unsigned EXT_LEN  = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pin_i,
  input  logic       drv_dis_ni,
  input  logic       sw_req_i,
  input  logic       wdt_req_i,
  input  logic       bden_set_i,
  input  logic       flag_clr_i,
  input  logic       ext_i,
  output logic       pin_pd_o,
  output logic       core_rst_o,
  output logic [3:0] flags_o
);
  logic              pin_f, bden, seq_start, flag_set;
  logic [FLAG_W-1:0] flag_val;

  rst_pin_filt #(.DLY(FILT_DLY)) i_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_i), .pin_f_o(pin_f)
  );

  rst_seq_fsm #(
    .SEQ_LEN(SEQ_LEN), .EXT_LEN(EXT_LEN), .SMP_DLY(SMP_DLY), .LONG_MIN(LONG_MIN)
  ) i_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_f_i(pin_f),
    .sw_req_i(sw_req_i), .wdt_req_i(wdt_req_i), .ext_i(ext_i),
    .bden_i(bden), .drv_dis_ni(drv_dis_ni),
    .pin_pd_o(pin_pd_o), .core_rst_o(core_rst_o), .seq_start_o(seq_start),
    .flag_set_o(flag_set), .flag_val_o(flag_val)
  );

  rst_src_flags i_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .flag_set_i(flag_set), .flag_val_i(flag_val),
    .flag_clr_i(flag_clr_i), .bden_set_i(bden_set_i), .seq_start_i(seq_start),
    .core_rst_i(core_rst_o), .flags_o(flags_o), .bden_o(bden)
  );
endmodule

// File: tb/test_rst_seq_ctrl.sv
module test_rst_seq_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ext_low = 1'b0, drv_dis_n = 1'b1, sw_req = 1'b0, wdt_req = 1'b0;
  logic bden_set = 1'b0, flag_clr = 1'b0, ext_opt = 1'b0;
  logic pin, pin_pd, core_rst;
  logic [3:0] flags;
  int n_cmp = 0, n_err = 0, cyc = 0;
  bit done = 0;

  localparam logic [3:0] F_SHORT = 4'b0001, F_LONG = 4'b0010, F_SW = 4'b0100, F_WDT = 4'b1000;

  assign pin = ~(pin_pd | ext_low);

  rst_seq_ctrl i_rst_seq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .drv_dis_ni(drv_dis_n),
    .sw_req_i(sw_req), .wdt_req_i(wdt_req), .bden_set_i(bden_set),
    .flag_clr_i(flag_clr), .ext_i(ext_opt),
    .pin_pd_o(pin_pd), .core_rst_o(core_rst), .flags_o(flags)
  );

  always #2 clk = ~clk;

  task automatic report();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_cmp++; n_err++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      report();
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_flag(bit wdt, bit drive, bit ext);
    if (drive && !ext) return F_SHORT;   // R9 degeneration
    return wdt ? F_WDT : F_SW;
  endfunction

  function automatic int exp_rst(bit ext);
    return ext ? 1048 : 1032;
  endfunction

  task automatic arm();
    @(negedge clk) bden_set = 1'b1;
    @(negedge clk) bden_set = 1'b0;
  endtask

  // issue a request; count cycles of pin pulldown and core reset
  task automatic run_seq(input bit sw, input bit wdt, input bit ext, input int dis_at,
                         input int bden_at, input int wdt_at,
                         output int pd_cnt, output int rst_cnt);
    @(negedge clk);
    sw_req = sw; wdt_req = wdt; ext_opt = ext;
    @(negedge clk);
    sw_req = 1'b0; wdt_req = 1'b0; ext_opt = 1'b0;
    pd_cnt = 0; rst_cnt = 0;
    while (core_rst && rst_cnt < 20000) begin
      if (rst_cnt == dis_at) begin drv_dis_n = 1'b0; #1; end
      bden_set = (rst_cnt == bden_at);
      wdt_req  = (rst_cnt == wdt_at);
      rst_cnt++;
      if (pin_pd) pd_cnt++;
      @(negedge clk);
    end
    bden_set = 1'b0; wdt_req = 1'b0; drv_dis_n = 1'b1;
  endtask

  task automatic hw_pulse(input int n, input string req, input logic [3:0] exp_f);
    int guard;
    @(negedge clk) ext_low = 1'b1;
    repeat (n) @(negedge clk);
    chk({req, " core reset during pin low"}, core_rst, 1);
    chk({req, " pin not driven by hw reset"}, pin_pd, 0);
    ext_low = 1'b0;
    guard = 0;
    while (core_rst && guard < 20000) begin guard++; @(negedge clk); end
    chk({req, " hw flag"}, flags, exp_f);
  endtask

  initial begin
    int pd, rl;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pin_pd after reset", pin_pd, 0);
    chk("R1 core_rst after reset", core_rst, 0);
    chk("R1 flags after reset", flags, 0);

    // R1/R4: disarmed after reset, software request
    run_seq(1, 0, 0, -1, -1, -1, pd, rl);
    chk("R1 no drive when disarmed", pd, 0);
    chk("R4 core reset length", rl, 1032);
    chk("R4 sw flag", flags, F_SW);

    // R4: watchdog wins a same-cycle tie
    run_seq(1, 1, 0, -1, -1, -1, pd, rl);
    chk("R4 wdt priority flag", flags, F_WDT);

    // R5/R9: armed software reset degenerates into short hw reset
    arm();
    run_seq(1, 0, 0, -1, -1, -1, pd, rl);
    chk("R5 pulldown length", pd, 1024);
    chk("R9 degenerated flag", flags, F_SHORT);

    // R10: extension avoids degeneration
    arm();
    run_seq(0, 1, 1, -1, -1, -1, pd, rl);
    chk("R10 pulldown length", pd, 1024);
    chk("R10 extended core reset", rl, 1048);
    chk("R10 wdt flag kept", flags, F_WDT);

    // R6: previous sequence disarmed; arm pulse during reset ignored
    run_seq(1, 0, 0, -1, 50, -1, pd, rl);
    chk("R6 disarmed by sequence", pd, 0);
    run_seq(1, 0, 1, -1, -1, -1, pd, rl);
    chk("R6 arm during reset ignored", pd, 0);
    chk("R6 ext length", rl, 1048);

    // R7: veto low at request
    arm();
    @(negedge clk) drv_dis_n = 1'b0;
    run_seq(1, 0, 1, -1, -1, -1, pd, rl);
    chk("R7 vetoed drive", pd, 0);
    chk("R7 core reset length", rl, 1048);
    chk("R7 flag", flags, F_SW);

    // R8: veto falls mid-drive; R11: request mid-sequence ignored
    arm();
    run_seq(1, 0, 0, 100, -1, 300, pd, rl);
    chk("R8 release at veto", pd, 100);
    chk("R8 full core reset", rl, 1032);
    chk("R11 mid-sequence wdt ignored", flags, F_SW);
    chk("R8 pin stays released", pin_pd, 0);

    // R11: clear
    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
    chk("R11 flags cleared", flags, 0);

    // R2/R3: hardware resets around the threshold
    hw_pulse(40, "R2 R3 short", F_SHORT);
    hw_pulse(1031, "R3 below threshold", F_SHORT);
    hw_pulse(1032, "R3 at threshold", F_LONG);
    chk("R11 flags persist after reset", flags, F_LONG);

    // random mix of arming, veto, extension and source
    for (int i = 0; i < 8; i++) begin
      bit wdt, armed, veto, ext, drive;
      wdt = $urandom % 2; armed = $urandom % 2; veto = $urandom % 2; ext = $urandom % 2;
      drive = armed && !veto;
      if (armed) arm();
      if (veto) @(negedge clk) drv_dis_n = 1'b0;
      run_seq(!wdt, wdt, ext, -1, -1, -1, pd, rl);
      chk("R5 R7 random pulldown", pd, drive ? 1024 : 0);
      chk("R9 R10 random flag", flags, exp_flag(wdt, drive, ext));
      if (!(drive && !ext)) chk("R4 R10 random length", rl, exp_rst(ext));
    end

    report();
  end
endmodule